// File: doc/BRIEF.md
# Generalized Bit-Reverse Permutation Unit

This block permutes the bits of a 64-bit operand under a 6-bit control word. Each control bit selects one swap stage. Stage k, when its bit is set, exchanges every adjacent pair of 2^k-bit blocks, so bit i moves to position i XOR 2^k. The stages run in a fixed ascending order, from single-bit swaps up to half-word swaps. A control word of zero leaves the operand unchanged. A control word of all ones reverses the whole word. Other values give nibble swaps, byte reversal, bit reversal within each byte, and many other regular shuffles.

A narrow mode serves 32-bit operations. In this mode the unit works on the low 32 bits of the operand, zero-extended, and it ignores the top control bit. The block is purely combinational. It also drives a carry flag, which this operation always clears. An execution stage places the block beside its other result sources and selects its output for this operation class.

Top module: `grev_unit`

## Requirements
- R1: For each k from 0 to 5 with control bit k set, the stage moves bit i to position i XOR 2^k. The stages apply in ascending k. With the operand bits numbered 0 (LSB) to 63, control 0x04 swaps the nibbles in every byte, 0x38 reverses the byte order, and 0x07 reverses the bits within each byte.
- R2: A control word of 0x00 in wide mode (`narrow_i` = 0) returns the operand unchanged.
- R3: A control word of 0x3F in wide mode returns the full bit reversal: result bit i equals operand bit 63-i.
- R4: With `narrow_i` = 1, operand bits 63:32 have no effect on the result. The operand is treated as its low 32 bits, zero-extended.
- R5: With `narrow_i` = 1, control bit 5 has no effect, so 0x3F acts as 0x1F and 0x20 acts as 0x00.
- R6: With `narrow_i` = 1, result bits 63:32 are always zero.
- R7: `carry_o` is 0 for every input.
- R8: In wide mode all 64 operand bits and all 6 control bits take part. Control 0x20 swaps the two 32-bit halves.
- R9: The result holds the same number of set bits as the effective operand, because the unit only permutes bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Operand to permute |
| ctrl_i | input | 6 | Swap-stage enables; bit k enables 2^k-bit block swaps |
| narrow_i | input | 1 | 1 = 32-bit mode (low word zero-extended, control bit 5 masked) |
| result_o | output | 64 | Permuted operand |
| carry_o | output | 1 | Carry flag, always 0 |

## Verification
Single-bit operands under single-stage controls show that each stage moves a bit by exactly its own block size, and that no two stages are confused. Structured patterns such as counting nibbles and a one-per-byte walk show how the stages combine: nibble swap, byte reversal and bit reversal within each byte would each produce a different word if a stage were missing or miswired. In narrow mode, operands with non-zero upper halves and controls with bit 5 set show whether the high word or the top stage leaks through. Random operands and controls in both modes are compared against a mask-and-shift reference model.

// File: rtl/grev_pkg.sv
package grev_pkg;

   // Default log2 of the datapath width.
   localparam int GREV_LOG2_W_DEF = 6;

   // Source position feeding bit idx when a stage of block size 2^k swaps.
   function automatic int partner_idx(input int idx, input int k);
      return idx ^ (1 << k);
   endfunction

   // Number of bits in one block at stage k.
   function automatic int block_bits(input int k);
      return 1 << k;
   endfunction

endpackage

// File: rtl/grev_swap_stage.sv
module grev_swap_stage #(
   parameter int W = 64,
   parameter int K = 0
) (
   input  logic [W-1:0] data_i,
   input  logic         en_i,
   output logic [W-1:0] data_o
);

   localparam int BLK = grev_pkg::block_bits(K);

   if (K < 0 || 2 * BLK > W) begin : g_bad_stage
      $fatal(1, "grev_swap_stage: block size %0d does not fit width %0d", BLK, W);
   end

   logic [W-1:0] swapped;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign swapped[i] = data_i[grev_pkg::partner_idx(i, K)];
   end

   assign data_o = en_i ? swapped : data_i;

endmodule

// File: rtl/grev_operand_prep.sv
module grev_operand_prep #(
   parameter int LOG2_W    = 6,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic [(1<<LOG2_W)-1:0] opnd_i,
   input  logic [LOG2_W-1:0]      ctrl_i,
   input  logic                   narrow_i,
   output logic [(1<<LOG2_W)-1:0] data_o,
   output logic [LOG2_W-1:0]      ctrl_o
);

   localparam int W  = 1 << LOG2_W;
   localparam int HW = W / 2;

   if (LOG2_W < 2) begin : g_bad_width
      $fatal(1, "grev_operand_prep: LOG2_W must be at least 2");
   end

   if (NARROW_EN) begin : g_narrow
      assign data_o = narrow_i ? {{HW{1'b0}}, opnd_i[HW-1:0]} : opnd_i;
      assign ctrl_o = narrow_i ? {1'b0, ctrl_i[LOG2_W-2:0]} : ctrl_i;
   end else begin : g_wide_only
      logic unused_narrow;
      assign unused_narrow = narrow_i;
      assign data_o        = opnd_i;
      assign ctrl_o        = ctrl_i;
   end

endmodule

// File: rtl/grev_unit.sv
module grev_unit #(
   parameter int LOG2_W    = grev_pkg::GREV_LOG2_W_DEF,
   parameter bit NARROW_EN = 1'b1
) (
   input  logic [(1<<LOG2_W)-1:0] opnd_i,
   input  logic [LOG2_W-1:0]      ctrl_i,
   input  logic                   narrow_i,
   output logic [(1<<LOG2_W)-1:0] result_o,
   output logic                   carry_o
);

   localparam int W = 1 << LOG2_W;

   if (LOG2_W < 2 || LOG2_W > 10) begin : g_bad_param
      $fatal(1, "grev_unit: LOG2_W %0d out of supported range", LOG2_W);
   end

   logic [W-1:0]      prep_data;
   logic [LOG2_W-1:0] prep_ctrl;
   logic [W-1:0]      lvl [LOG2_W+1];

   grev_operand_prep #(
      .LOG2_W   (LOG2_W),
      .NARROW_EN(NARROW_EN)
   ) u_prep (
      .opnd_i  (opnd_i),
      .ctrl_i  (ctrl_i),
      .narrow_i(narrow_i),
      .data_o  (prep_data),
      .ctrl_o  (prep_ctrl)
   );

   assign lvl[0] = prep_data;

   // Ascending stage order: finest swaps first.
   for (genvar k = 0; k < LOG2_W; k++) begin : g_stage
      grev_swap_stage #(
         .W(W),
         .K(k)
      ) u_swap (
         .data_i(lvl[k]),
         .en_i  (prep_ctrl[k]),
         .data_o(lvl[k+1])
      );
   end

   assign result_o = lvl[LOG2_W];
   assign carry_o  = 1'b0;

endmodule

// File: rtl/grev_unit_chk.sv
module grev_unit_chk #(
   parameter int LOG2_W    = 6,
   parameter bit NARROW_EN = 1'b1
) (
   input logic [(1<<LOG2_W)-1:0] opnd_i,
   input logic [LOG2_W-1:0]      ctrl_i,
   input logic                   narrow_i,
   input logic [(1<<LOG2_W)-1:0] result_o,
   input logic                   carry_o
);

   localparam int W  = 1 << LOG2_W;
   localparam int HW = W / 2;

   logic [W-1:0] rev_opnd;
   logic [W-1:0] eff_opnd;
   logic         narrow_act;

   always_comb begin
      for (int i = 0; i < W; i++) rev_opnd[i] = opnd_i[W-1-i];
   end

   assign narrow_act = NARROW_EN && narrow_i;
   assign eff_opnd   = narrow_act ? {{HW{1'b0}}, opnd_i[HW-1:0]} : opnd_i;

   always_comb begin
      AST_CARRY_CLEAR: assert (carry_o == 1'b0) else $error("carry set"); // R7
      if (!narrow_i && ctrl_i == '0) begin
         AST_ZERO_CTRL_IDENTITY: assert (result_o == opnd_i) else $error("identity broken"); // R2
      end
      if (!narrow_i && (&ctrl_i)) begin
         AST_ALL_ONES_REVERSE: assert (result_o == rev_opnd) else $error("reversal broken"); // R3
      end
      if (narrow_act) begin
         AST_NARROW_HIGH_ZERO: assert (result_o[W-1:HW] == '0) else $error("narrow high word set"); // R6
      end
      AST_POPCOUNT_KEPT: assert ($countones(result_o) == $countones(eff_opnd)) else $error("bit count changed"); // R9
   end

endmodule

bind grev_unit grev_unit_chk #(
   .LOG2_W   (LOG2_W),
   .NARROW_EN(NARROW_EN)
) u_chk (
   .opnd_i  (opnd_i),
   .ctrl_i  (ctrl_i),
   .narrow_i(narrow_i),
   .result_o(result_o),
   .carry_o (carry_o)
);

// File: tb/grev_unit_bench.sv
`timescale 1ns/1ps
module grev_unit_bench;

   logic        clk = 1'b0;
   logic [63:0] opnd = '0;
   logic [5:0]  ctrl = '0;
   logic        narrow = 1'b0;
   logic [63:0] result;
   logic        carry;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   grev_unit u_grev_unit (
      .opnd_i  (opnd),
      .ctrl_i  (ctrl),
      .narrow_i(narrow),
      .result_o(result),
      .carry_o (carry)
   );

   typedef struct packed {
      logic        nw;
      logic [5:0]  c;
      logic [63:0] x;
      logic [63:0] y;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 6'h00, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF}, // R2
      '{1'b0, 6'h01, 64'h0000000000000001, 64'h0000000000000002}, // R1
      '{1'b0, 6'h20, 64'h0000000000000001, 64'h0000000100000000}, // R8
      '{1'b0, 6'h04, 64'h0123456789ABCDEF, 64'h1032547698BADCFE}, // R1
      '{1'b0, 6'h38, 64'h0123456789ABCDEF, 64'hEFCDAB8967452301}, // R1
      '{1'b0, 6'h07, 64'h0102040810204080, 64'h8040201008040201}, // R1
      '{1'b0, 6'h3F, 64'h0000000000000001, 64'h8000000000000000}, // R3
      '{1'b0, 6'h3F, 64'h00000000000000F0, 64'h0F00000000000000}, // R3
      '{1'b1, 6'h18, 64'hFFFFFFFF01234567, 64'h0000000067452301}, // R4
      '{1'b1, 6'h3F, 64'hFFFFFFFF00000001, 64'h0000000080000000}, // R5
      '{1'b1, 6'h20, 64'hDEADBEEF12345678, 64'h0000000012345678}, // R5
      '{1'b1, 6'h1F, 64'hFFFFFFFFFFFFFFFF, 64'h00000000FFFFFFFF}  // R6
   };

   function automatic logic [63:0] ref_grev(input logic [63:0] x_in,
                                            input logic [5:0] c_in,
                                            input logic nw);
      logic [63:0] m [6];
      logic [63:0] x;
      logic [5:0]  c;
      m[0] = 64'h5555555555555555;
      m[1] = 64'h3333333333333333;
      m[2] = 64'h0F0F0F0F0F0F0F0F;
      m[3] = 64'h00FF00FF00FF00FF;
      m[4] = 64'h0000FFFF0000FFFF;
      m[5] = 64'h00000000FFFFFFFF;
      x = nw ? {32'h0, x_in[31:0]} : x_in;
      c = nw ? {1'b0, c_in[4:0]} : c_in;
      for (int k = 0; k < 6; k++) begin
         if (c[k]) x = ((x & m[k]) << (1 << k)) | ((x >> (1 << k)) & m[k]);
      end
      return x;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic apply(input logic nw, input logic [5:0] c, input logic [63:0] x);
      @(negedge clk);
      narrow = nw;
      ctrl   = c;
      opnd   = x;
      #2;
   endtask

   initial begin
      logic [63:0] first;
      logic [63:0] x;
      logic [5:0]  c;

      // Idle state: zero inputs give a zero result and a clear carry.
      apply(1'b0, 6'h00, 64'h0);
      check("R2", result, 64'h0);
      check("R7", {63'h0, carry}, 64'h0);

      for (int v = 0; v < NV; v++) begin
         apply(VEC[v].nw, VEC[v].c, VEC[v].x);
         check(v < 8 ? "R1/R2/R3/R8" : "R4/R5/R6", result, VEC[v].y);
         check("R7", {63'h0, carry}, 64'h0);
      end

      // R4: upper operand bits ignored in narrow mode
      for (int t = 0; t < 20; t++) begin
         x = {$urandom, $urandom};
         c = 6'($urandom);
         apply(1'b1, c, x);
         first = result;
         apply(1'b1, c, {~x[63:32], x[31:0]});
         check("R4", result, first);
      end

      // R5: control bit 5 ignored in narrow mode
      for (int t = 0; t < 20; t++) begin
         x = {$urandom, $urandom};
         c = 6'($urandom);
         apply(1'b1, {1'b0, c[4:0]}, x);
         first = result;
         apply(1'b1, {1'b1, c[4:0]}, x);
         check("R5", result, first);
         check("R6", {32'h0, result[63:32]}, 64'h0);
      end

      // R1 / R8 / R9: random operands in both modes against the reference
      for (int t = 0; t < 400; t++) begin
         x = {$urandom, $urandom};
         c = 6'($urandom);
         apply(t[0], c, x);
         check(t[0] ? "R1 narrow" : "R8", result, ref_grev(x, c, t[0]));
         check("R9", 64'($countones(result)),
               64'($countones(t[0] ? {32'h0, x[31:0]} : x)));
         check("R7", {63'h0, carry}, 64'h0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule